// File: doc/BRIEF.md
# Serial Slave with Trailing Status Word

This block is the device side of a four-wire SPI link (mode 0: SCLK idles low, MOSI is sampled on the rising edge, MISO changes on the falling edge). Every transaction starts with a 32-bit command word. A payload of whole 16-bit words follows. The block then sends a 32-bit status word on its own, so the host learns about FIFO trouble and receive-packet readiness in the same chip-select window, without a second access.

On the core side, payload words for data functions 1 to 3 go into a write FIFO or come out of a read FIFO. The read FIFO shows its head word ahead of the pop. Function 0 reaches a small control space, which holds a wake bit and an interrupt mask and reports pending interrupt causes. A level interrupt to the host is raised while the device is awake and an unmasked cause is pending. The SPI pins are brought into the system clock domain with a synchronizer chain, so SCLK must run well below the system clock.

Top module: `spi_stat_slave`

## Requirements
- R1: The command word is 32 bits, MSB first. Bit 31 selects write, bit 30 selects address increment, bits 29:28 hold the function, bits 27:11 hold the address and bits 10:0 hold a byte count. The payload has ceil(count/2) words of 16 bits, MSB first. A count of 0 means no payload, and the status word follows the command directly.
- R2: For a write to function 1, 2 or 3, each complete 16-bit word is presented once on `wf_data` with a one-cycle `wf_push`, in arrival order.
- R3: A write word that arrives while `wf_full` is high is dropped, and status bit 2 (overflow) is set.
- R4: For a read from function 1, 2 or 3, read-FIFO words appear on MISO starting with the first falling SCLK edge after the command. Each word consumes exactly one FIFO entry.
- R5: A read word fetched from an empty FIFO is sent as zero and sets status bit 1 (underflow). If the FIFO is empty when the first word is fetched, status bit 0 (no data) is also set.
- R6: After the payload, a 32-bit status word is sent MSB first. Its bits are: 0 no data, 1 underflow, 2 overflow, 3 `core_f2_irq` level, 5 `core_rx_ready`, 8 `core_pkt_avail`, 19:9 `core_pkt_len`. All other bits are zero.
- R7: The no-data, underflow and overflow flags cover one transaction only. They are cleared when chip select is next asserted.
- R8: Releasing chip select at any point aborts the transaction. A partial word is never pushed, and the next transaction is decoded from a fresh command.
- R9: A function-0 write to address 0 loads `wake` from data bit 0. A write to address 1 loads the interrupt mask from data bits 2:0. With increment set, the address advances by one per word. After reset, `wake` is 0 and the mask is 3'b111.
- R10: Three pending causes exist: bit 0 is set when `wake` goes from 0 to 1, bit 1 on a rising `core_f2_irq`, and bit 2 on a rising `core_pkt_avail`. `host_irq` is high exactly while `wake` is 1 and some pending bit is unmasked.
- R11: Every word of a function-0 read returns {13'b0, pending[2:0]}. All pending bits are cleared when the status word of that read is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-device data |
| spi_miso | output | 1 | Device-to-host data |
| wf_push | output | 1 | Write-FIFO push strobe |
| wf_data | output | 16 | Word pushed to write FIFO |
| wf_full | input | 1 | Write FIFO full |
| rf_pop | output | 1 | Read-FIFO pop strobe |
| rf_data | input | 16 | Read-FIFO head word |
| rf_empty | input | 1 | Read FIFO empty |
| core_f2_irq | input | 1 | Channel-2 interrupt level from core |
| core_rx_ready | input | 1 | Channel-2 receive FIFO empty and ready |
| core_pkt_avail | input | 1 | Packet waiting in transmit FIFO |
| core_pkt_len | input | 11 | Length of waiting packet |
| host_irq | output | 1 | Interrupt to host |
| wake | output | 1 | Wake control bit |

## Verification
The SCLK and chip-select pins pass through two synchronizer flops and one edge register. A MISO bit that is launched on a falling SCLK edge is therefore valid about three system clocks later. The bench holds each SCLK phase for six clocks and samples MISO just before it raises SCLK. Write-FIFO pushes and read-FIFO pops occur in the single cycle after the edge that completes or starts a word, so the scoreboard monitor compares each push in the cycle it is strobed. Interrupt, wake and flag effects settle within a few clocks of the final edge. The bench checks them only after chip select has been released and eight further clocks have passed.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int CMD_W  = 32;
  localparam int WORD_W = 16;
  localparam int STAT_W = 32;
  localparam int LEN_W  = 11;
  localparam int ADDR_W = 17;
  localparam int FN_W   = 2;
  localparam int CNT_W  = $clog2(CMD_W);
  localparam int N_EV   = 3;

  typedef struct packed {
    logic              wr;
    logic              inc;
    logic [FN_W-1:0]   fn;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  nbytes;
  } cmd_t;

  typedef enum logic [1:0] {PH_CMD, PH_DATA, PH_STAT, PH_DONE} phase_t;

  // number of 16-bit payload words for a byte count (rounded up)
  function automatic logic [LEN_W-1:0] words_for(input logic [LEN_W-1:0] nb);
    logic [LEN_W:0] t;
    t = ({1'b0, nb} + 1'b1) >> 1;
    return t[LEN_W-1:0];
  endfunction

  function automatic logic [STAT_W-1:0] build_status(
    input logic navail, input logic unf, input logic ovf,
    input logic f2irq, input logic rxrdy, input logic pkt,
    input logic [LEN_W-1:0] len);
    logic [STAT_W-1:0] s;
    s = '0;
    s[0] = navail;
    s[1] = unf;
    s[2] = ovf;
    s[3] = f2irq;
    s[5] = rxrdy;
    s[8] = pkt;
    s[9 +: LEN_W] = len;
    return s;
  endfunction
endpackage

// File: rtl/spi_stat_sync.sv
module spi_stat_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int TOT = W * STAGES;
  logic [TOT-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST}};
    else        chain <= {chain[TOT-W-1:0], d};
  end

  assign q = chain[TOT-1 -: W];
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic         clr,
  input  logic [N-1:0] mask,
  input  logic         wake,
  output logic [N-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~{N{clr}}) | set_ev;
  end

  assign irq = wake & (|(pend & mask));

  AST_IRQ_NEEDS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> wake); // R10
  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev) |=> ((pend & $past(set_ev)) == $past(set_ev))); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_ev == '0) |=> (pend == '0)); // R11
endmodule

// File: rtl/spi_stat_slave.sv
module spi_stat_slave
  import spi_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              wf_push,
  output logic [WORD_W-1:0] wf_data,
  input  logic              wf_full,
  output logic              rf_pop,
  input  logic [WORD_W-1:0] rf_data,
  input  logic              rf_empty,
  input  logic              core_f2_irq,
  input  logic              core_rx_ready,
  input  logic              core_pkt_avail,
  input  logic [LEN_W-1:0]  core_pkt_len,
  output logic              host_irq,
  output logic              wake
);
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_W - 1);

  // pin synchronization and edge detection
  logic [2:0] pins_q;
  spi_stat_sync #(.W(3), .STAGES(2), .RST(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_sclk, spi_mosi}), .q(pins_q));

  logic cs_s, sclk_s, mosi_s, cs_d, sclk_d;
  assign cs_s   = pins_q[2];
  assign sclk_s = pins_q[1];
  assign mosi_s = pins_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  logic cs_act, cs_on, rise_ev, fall_ev;
  assign cs_act  = ~cs_s;
  assign cs_on   = ~cs_s & cs_d;
  assign rise_ev = cs_act & sclk_s & ~sclk_d;
  assign fall_ev = cs_act & ~sclk_s & sclk_d;

  // state
  phase_t                   phase;
  logic [CNT_W-1:0]         bitcnt;
  logic [CMD_W-2:0]         cmd_sr;
  logic [WORD_W-2:0]        rx_sr;
  logic [STAT_W-1:0]        tx_sr;
  logic                     cmd_wr, cmd_inc;
  logic [FN_W-1:0]          cmd_fn;
  logic [ADDR_W-1:0]        addr_q;
  logic [LEN_W-1:0]         words_left;
  logic                     first_word;
  logic                     fl_navail, fl_unf, fl_ovf;
  logic [N_EV-1:0]          mask_q;
  logic                     f2_d, pkt_d;

  // named events
  cmd_t              cmd_now;
  logic [WORD_W-1:0] rx_word;
  logic              cmd_done, word_done, stat_done;
  logic              load_word, load_stat, fifo_rd, data_wr, reg_wr;
  logic              wake_rise, clr_pend;
  logic [N_EV-1:0]   pend, set_ev;
  logic [WORD_W-1:0] rd_word;
  logic [LEN_W-1:0]  nwords_now;

  assign cmd_now    = cmd_t'({cmd_sr, mosi_s});
  assign rx_word    = {rx_sr, mosi_s};
  assign nwords_now = words_for(cmd_now.nbytes);
  assign cmd_done   = rise_ev && phase == PH_CMD  && bitcnt == CMD_LAST;
  assign word_done  = rise_ev && phase == PH_DATA && bitcnt == WORD_LAST;
  assign stat_done  = rise_ev && phase == PH_STAT && bitcnt == STAT_LAST;
  assign load_word  = fall_ev && phase == PH_DATA && bitcnt == '0 && !cmd_wr;
  assign load_stat  = fall_ev && phase == PH_STAT && bitcnt == '0;
  assign fifo_rd    = load_word && cmd_fn != '0;
  assign data_wr    = word_done && cmd_wr && cmd_fn != '0;
  assign reg_wr     = word_done && cmd_wr && cmd_fn == '0;
  assign wake_rise  = reg_wr && addr_q == '0 && rx_word[0] && !wake;
  assign clr_pend   = load_stat && !cmd_wr && cmd_fn == '0;
  assign set_ev     = {core_pkt_avail & ~pkt_d, core_f2_irq & ~f2_d, wake_rise};

  always_comb begin
    if (cmd_fn == '0)   rd_word = WORD_W'(pend);
    else if (rf_empty)  rd_word = '0;
    else                rd_word = rf_data;
  end

  assign wf_push  = data_wr && !wf_full;
  assign wf_data  = rx_word;
  assign rf_pop   = fifo_rd && !rf_empty;
  assign spi_miso = tx_sr[STAT_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f2_d  <= 1'b0;
      pkt_d <= 1'b0;
    end else begin
      f2_d  <= core_f2_irq;
      pkt_d <= core_pkt_avail;
    end
  end

  // control registers reached through function 0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake   <= 1'b0;
      mask_q <= '1;
    end else if (reg_wr) begin
      if (addr_q == ADDR_W'(0)) wake   <= rx_word[0];
      if (addr_q == ADDR_W'(1)) mask_q <= rx_word[N_EV-1:0];
    end
  end

  // transaction sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_CMD;
      bitcnt     <= '0;
      cmd_sr     <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      cmd_wr     <= 1'b0;
      cmd_inc    <= 1'b0;
      cmd_fn     <= '0;
      addr_q     <= '0;
      words_left <= '0;
      first_word <= 1'b0;
      fl_navail  <= 1'b0;
      fl_unf     <= 1'b0;
      fl_ovf     <= 1'b0;
    end else if (!cs_act) begin
      phase  <= PH_CMD;
      bitcnt <= '0;
      tx_sr  <= '0;
    end else begin
      if (cs_on) begin
        fl_navail <= 1'b0;
        fl_unf    <= 1'b0;
        fl_ovf    <= 1'b0;
      end
      if (rise_ev) begin
        unique case (phase)
          PH_CMD: begin
            cmd_sr <= {cmd_sr[CMD_W-3:0], mosi_s};
            bitcnt <= bitcnt + 1'b1;
            if (cmd_done) begin
              cmd_wr     <= cmd_now.wr;
              cmd_inc    <= cmd_now.inc;
              cmd_fn     <= cmd_now.fn;
              addr_q     <= cmd_now.addr;
              words_left <= nwords_now;
              first_word <= 1'b1;
              bitcnt     <= '0;
              phase      <= (nwords_now == '0) ? PH_STAT : PH_DATA;
            end
          end
          PH_DATA: begin
            rx_sr  <= rx_word[WORD_W-2:0];
            bitcnt <= bitcnt + 1'b1;
            if (word_done) begin
              bitcnt     <= '0;
              first_word <= 1'b0;
              words_left <= words_left - 1'b1;
              if (cmd_inc) addr_q <= addr_q + 1'b1;
              if (words_left == LEN_W'(1)) phase <= PH_STAT;
              if (data_wr && wf_full) fl_ovf <= 1'b1;
            end
          end
          PH_STAT: begin
            bitcnt <= bitcnt + 1'b1;
            if (stat_done) phase <= PH_DONE;
          end
          default: ;
        endcase
      end
      if (fall_ev) begin
        if (load_word)      tx_sr <= {rd_word, {(STAT_W-WORD_W){1'b0}}};
        else if (load_stat) tx_sr <= build_status(fl_navail, fl_unf, fl_ovf, core_f2_irq,
                                                  core_rx_ready, core_pkt_avail, core_pkt_len);
        else                tx_sr <= {tx_sr[STAT_W-2:0], 1'b0};
        if (fifo_rd && rf_empty) begin
          fl_unf <= 1'b1;
          if (first_word) fl_navail <= 1'b1;
        end
      end
    end
  end

  spi_stat_irq #(.N(N_EV)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr(clr_pend),
    .mask(mask_q), .wake(wake), .pend(pend), .irq(host_irq));

  AST_CMD_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> phase != PH_CMD); // R1
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wf_push |=> !wf_push); // R2
  AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_pop |=> !rf_pop); // R4
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_unf && cs_act && !cs_on) |=> fl_unf); // R5
  AST_STAT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    load_stat |=> (tx_sr[4] == 1'b0 && tx_sr[7:6] == 2'b00 && tx_sr[31:20] == '0)); // R6
  AST_FLAGS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && !rise_ev && !fall_ev) |=> !(fl_unf || fl_ovf || fl_navail)); // R7
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_CMD && bitcnt == '0 && !spi_miso)); // R8
endmodule

// File: tb/spi_stat_slave_test.sv
module spi_stat_slave_test;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, wf_push, rf_pop, host_irq, wake;
  logic [15:0] wf_data;
  logic wf_full = 1'b0;
  logic [15:0] rf_data = '0;
  logic rf_empty = 1'b1;
  logic core_f2_irq = 1'b0, core_rx_ready = 1'b0, core_pkt_avail = 1'b0;
  logic [10:0] core_pkt_len = '0;

  always #10 clk = ~clk;

  spi_stat_slave uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .wf_push(wf_push), .wf_data(wf_data),
    .wf_full(wf_full), .rf_pop(rf_pop), .rf_data(rf_data), .rf_empty(rf_empty),
    .core_f2_irq(core_f2_irq), .core_rx_ready(core_rx_ready),
    .core_pkt_avail(core_pkt_avail), .core_pkt_len(core_pkt_len),
    .host_irq(host_irq), .wake(wake));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_wf[$];
  logic [15:0] exp_rd[$];
  logic [15:0] rf_q[$];
  logic [15:0] txw[0:7];
  logic [15:0] rxw[0:7];
  bit pop_pend = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // read-FIFO model and write-FIFO scoreboard monitor
  always @(negedge clk) begin
    if (pop_pend && rf_q.size() > 0) void'(rf_q.pop_front());
    pop_pend = rf_pop;
    rf_empty = (rf_q.size() == 0);
    rf_data  = (rf_q.size() > 0) ? rf_q[0] : 16'h0;
    if (wf_push) begin
      if (exp_wf.size() == 0) check(1'b0, "R2 unexpected push", {16'h0, wf_data}, 32'h0);
      else begin
        logic [15:0] e;
        e = exp_wf.pop_front();
        check(wf_data == e, "R2 pushed word", {16'h0, wf_data}, {16'h0, e});
      end
    end
  end

  function automatic logic [31:0] mk_cmd(input bit wr, input bit inc, input logic [1:0] fn,
                                        input logic [16:0] addr, input logic [10:0] nb);
    return {wr, inc, fn, addr, nb};
  endfunction

  function automatic logic [31:0] exp_stat(input bit nav, input bit unf, input bit ovf);
    return {12'h0, core_pkt_len, core_pkt_avail, 2'b00, core_rx_ready, 1'b0,
            core_f2_irq, ovf, unf, nav};
  endfunction

  task automatic xfer(input logic [31:0] cmd, input int nw, input int cut, output logic [31:0] stat);
    int total;
    total = 64 + 16 * nw;
    stat = '0;
    @(negedge clk) spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int b = 0; b < total; b++) begin
      if (cut > 0 && b == cut) break;
      if (b < 32)             spi_mosi = cmd[31-b];
      else if (b < 32 + 16*nw) spi_mosi = txw[(b-32)/16][15-((b-32)%16)];
      else                     spi_mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      if (b >= 32 && b < 32 + 16*nw) rxw[(b-32)/16][15-((b-32)%16)] = spi_miso;
      else if (b >= 32 + 16*nw)      stat[31-(b-32-16*nw)] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic check_reads(input int nw, input string tag);
    for (int i = 0; i < nw; i++) begin
      logic [15:0] e;
      e = exp_rd.pop_front();
      check(rxw[i] == e, tag, {16'h0, rxw[i]}, {16'h0, e});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state, R9 R10
    check(wake == 1'b0, "R9 wake after reset", {31'h0, wake}, 32'h0);
    check(host_irq == 1'b0, "R10 irq after reset", {31'h0, host_irq}, 32'h0);
    check(spi_miso == 1'b0 && wf_push == 1'b0, "R8 idle outputs", {30'h0, spi_miso, wf_push}, 32'h0);
    core_rx_ready = 1'b1;

    // R2 plain write of two words
    txw[0] = 16'hA5A5; txw[1] = 16'h1234;
    exp_wf.push_back(16'hA5A5); exp_wf.push_back(16'h1234);
    xfer(mk_cmd(1, 1, 2'd1, 17'h10, 11'd4), 2, 0, st);
    check(st == exp_stat(0, 0, 0), "R6 status after write", st, exp_stat(0, 0, 0));
    // R1 odd byte count rounds up
    txw[0] = 16'h0F0F; txw[1] = 16'hBEEF;
    exp_wf.push_back(16'h0F0F); exp_wf.push_back(16'hBEEF);
    xfer(mk_cmd(1, 0, 2'd3, 17'h0, 11'd3), 2, 0, st);
    check(exp_wf.size() == 0, "R1 odd count words", exp_wf.size(), 0);
    // R3 overflow
    wf_full = 1'b1;
    txw[0] = 16'h7777;
    xfer(mk_cmd(1, 0, 2'd1, 17'h0, 11'd2), 1, 0, st);
    check(st == exp_stat(0, 0, 1), "R3 overflow bit", st, exp_stat(0, 0, 1));
    wf_full = 1'b0;
    // R7 flag cleared next transaction
    txw[0] = 16'h4321; exp_wf.push_back(16'h4321);
    xfer(mk_cmd(1, 0, 2'd1, 17'h0, 11'd2), 1, 0, st);
    check(st == exp_stat(0, 0, 0), "R7 flags cleared", st, exp_stat(0, 0, 0));

    // R4 read of three words, new core status values
    core_pkt_avail = 1'b1; core_pkt_len = 11'h2A3; core_f2_irq = 1'b0;
    for (int i = 0; i < 8; i++) txw[i] = '0;
    rf_q.push_back(16'hC001); rf_q.push_back(16'h8002); rf_q.push_back(16'h0003);
    exp_rd.push_back(16'hC001); exp_rd.push_back(16'h8002); exp_rd.push_back(16'h0003);
    repeat (2) @(negedge clk);
    xfer(mk_cmd(0, 1, 2'd2, 17'h0, 11'd6), 3, 0, st);
    check_reads(3, "R4 read word");
    check(st == exp_stat(0, 0, 0), "R6 status fields", st, exp_stat(0, 0, 0));
    check(rf_q.size() == 0, "R4 entries consumed", rf_q.size(), 0);
    // R5 underflow on second word
    rf_q.push_back(16'h5A5A); exp_rd.push_back(16'h5A5A); exp_rd.push_back(16'h0000);
    repeat (2) @(negedge clk);
    xfer(mk_cmd(0, 0, 2'd2, 17'h0, 11'd4), 2, 0, st);
    check_reads(2, "R5 underflow word");
    check(st == exp_stat(0, 1, 0), "R5 underflow only", st, exp_stat(0, 1, 0));
    // R5 empty at first word
    exp_rd.push_back(16'h0000);
    xfer(mk_cmd(0, 0, 2'd1, 17'h0, 11'd2), 1, 0, st);
    check_reads(1, "R5 empty word");
    check(st == exp_stat(1, 1, 0), "R5 no-data and underflow", st, exp_stat(1, 1, 0));
    // R1 zero byte count
    xfer(mk_cmd(1, 0, 2'd1, 17'h0, 11'd0), 0, 0, st);
    check(st == exp_stat(0, 0, 0), "R1 zero count status", st, exp_stat(0, 0, 0));

    // R8 aborts
    txw[0] = 16'h1111; txw[1] = 16'h2222; exp_wf.push_back(16'h1111);
    xfer(mk_cmd(1, 0, 2'd1, 17'h0, 11'd4), 2, 56, st);
    xfer(mk_cmd(1, 0, 2'd1, 17'h0, 11'd4), 2, 20, st);
    txw[0] = 16'h3333; exp_wf.push_back(16'h3333);
    xfer(mk_cmd(1, 0, 2'd1, 17'h0, 11'd2), 1, 0, st);
    check(exp_wf.size() == 0, "R8 abort then recover", exp_wf.size(), 0);
    check(st == exp_stat(0, 0, 0), "R8 status after abort", st, exp_stat(0, 0, 0));

    // R9 R10 wake
    txw[0] = 16'h0001;
    xfer(mk_cmd(1, 0, 2'd0, 17'h0, 11'd2), 1, 0, st);
    check(wake == 1'b1, "R9 wake set", {31'h0, wake}, 32'h1);
    check(host_irq == 1'b1, "R10 irq after wake", {31'h0, host_irq}, 32'h1);
    // R11 read pending, clears
    txw[0] = 16'h0; exp_rd.push_back(16'h0005);
    xfer(mk_cmd(0, 0, 2'd0, 17'h0, 11'd2), 1, 0, st);
    check_reads(1, "R11 pending word");
    check(host_irq == 1'b0, "R11 irq cleared", {31'h0, host_irq}, 32'h0);
    // R10 mask
    core_f2_irq = 1'b1;
    repeat (4) @(negedge clk);
    check(host_irq == 1'b1, "R10 f2 rise irq", {31'h0, host_irq}, 32'h1);
    txw[0] = 16'h0005;
    xfer(mk_cmd(1, 0, 2'd0, 17'h1, 11'd2), 1, 0, st);
    check(host_irq == 1'b0, "R10 masked cause", {31'h0, host_irq}, 32'h0);
    // R9 incrementing address writes wake then mask
    txw[0] = 16'h0001; txw[1] = 16'h0007;
    xfer(mk_cmd(1, 1, 2'd0, 17'h0, 11'd4), 2, 0, st);
    check(host_irq == 1'b1, "R9 mask via increment", {31'h0, host_irq}, 32'h1);
    txw[0] = 16'h0; txw[1] = 16'h0; exp_rd.push_back(16'h0002); exp_rd.push_back(16'h0002);
    xfer(mk_cmd(0, 0, 2'd0, 17'h0, 11'd4), 2, 0, st);
    check_reads(2, "R11 pending f2");
    check(st == exp_stat(0, 0, 0), "R6 status f2 level", st, exp_stat(0, 0, 0));
    check(host_irq == 1'b0, "R11 irq cleared again", {31'h0, host_irq}, 32'h0);
    // R10 asleep suppresses irq
    txw[0] = 16'h0000;
    xfer(mk_cmd(1, 0, 2'd0, 17'h0, 11'd2), 1, 0, st);
    check(wake == 1'b0, "R9 wake cleared", {31'h0, wake}, 32'h0);
    core_f2_irq = 1'b0;
    repeat (3) @(negedge clk);
    core_f2_irq = 1'b1;
    repeat (4) @(negedge clk);
    check(host_irq == 1'b0, "R10 no irq while asleep", {31'h0, host_irq}, 32'h0);
    check(exp_wf.size() == 0, "R2 scoreboard drained", exp_wf.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule